// File: doc/BRIEF.md
# Addressable Bit Latch with Demultiplexer Mode

This block holds a small bank of individually addressable storage bits behind one serial data input. An address chooses one bit. An active-low enable opens that bit to the data input. An active-low conditional clear either wipes the whole bank or, while the enable is active, forces every unselected output low. The combination of clear and enable levels gives four behaviours: addressable write, hold, one-hot demultiplexer and clear-all.

The design is synchronous. A free-running clock samples the inputs and keeps the stored bits in flip-flops. The path from the data input to the selected output while enabled is combinational, so the selected output follows the data input in the same cycle. The stored bit is written in the cycle where the enable is first sampled inactive after being active. The address must be held steady while the enable is active. If it is not, only the address present at that closing edge is written.

Top module: `addr_bit_latch`

## Requirements
- R1: With `rst` high at a clock edge, all stored bits become 0. With clear and enable both inactive afterwards, `q` reads 0.
- R2: Output index `sel` = sel[2]*4 + sel[1]*2 + sel[0] (sel[2] is the most significant bit). `sel`=0 picks q[0] and `sel`=7 picks q[7].
- R3: With `clr_n`=1 and `en_n`=0, q[sel] equals `din` in the same cycle. Every other output shows its stored value.
- R4: With `clr_n`=1 and `en_n`=1, and no closing edge pending, changes on `din` and `sel` leave all outputs unchanged.
- R5: In a cycle where `en_n` is sampled 1 after being sampled 0 at the previous edge, with `clr_n`=1, the bit at `sel` stores `din` from that edge. It is visible on `q` from then on.
- R6: With `clr_n`=0 and `en_n`=1, `q` is all zeros in the same cycle, and every stored bit is 0 after the edge.
- R7: With `clr_n`=0 and `en_n`=0, q[sel] equals `din` and all other outputs are 0, which forms a 1-to-8 demultiplexer. The unselected stored bits are 0 after the edge.
- R8: If `sel` changes while `en_n`=0, a bit that was selected earlier in that window keeps its previously stored value. Only the bit at the closing-edge address is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data input |
| sel | input | ADDR_W | Bit address, MSB first |
| en_n | input | 1 | Enable, active low |
| clr_n | input | 1 | Conditional clear, active low |
| q | output | 2**ADDR_W | Bit outputs |

## Verification
The hardest case to reach is an address that moves while the enable is active. The bit selected first must keep its old content, even though it showed live data for a few cycles. The stimulus stores a known pattern first. It then opens the enable on one address, drives the opposite data value, and moves to a second address before closing. Afterwards it reads every bit back in hold mode. The sweep also covers all four clear/enable combinations at every address with both data levels, including a closing edge that coincides with an active clear.

// File: rtl/addr_bit_latch.sv
module addr_bit_latch #(
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     din,
  input  logic [ADDR_W-1:0]        sel,
  input  logic                     en_n,
  input  logic                     clr_n,
  output logic [(1<<ADDR_W)-1:0]   q
);
  localparam int NUM = 1 << ADDR_W;

  logic [NUM-1:0] st;
  logic [NUM-1:0] hit;
  logic           en_n_q;
  logic           rise;

  assign hit  = en_n ? '0 : (NUM'(1) << sel);
  assign rise = en_n & ~en_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= '0;
      en_n_q <= 1'b1;
    end else begin
      en_n_q <= en_n;
      if (!clr_n)
        st <= st & hit;
      else if (rise)
        st[sel] <= din;
    end
  end

  assign q = (hit & {NUM{din}}) | (st & ~hit & {NUM{clr_n}});

  p_transparent_r3: assert property (@(posedge clk) disable iff (rst)
    !en_n |-> q[sel] == din);
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_n && en_n && en_n_q) |=> $stable(st));
  p_capture_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_n && en_n && !en_n_q) |=> st[$past(sel)] == $past(din));
  p_clear_all_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr_n && en_n) |-> (q == '0));
  p_clear_all_st_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr_n && en_n) |=> (st == '0));
  p_demux_r7: assert property (@(posedge clk) disable iff (rst)
    (!clr_n && !en_n) |-> ($countones(q) <= 1));
  p_open_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !en_n) |=> $stable(st));
endmodule

// File: tb/addr_bit_latch_tb_top.sv
`timescale 1ns/1ps
module addr_bit_latch_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic [2:0] sel = '0;
  logic en_n = 1'b1;
  logic clr_n = 1'b1;
  logic [7:0] q;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl = '0;
  logic m_prev = 1'b1;

  always #2.5 clk = ~clk;

  addr_bit_latch #(.ADDR_W(3)) dut_i (
    .clk(clk), .rst(rst), .din(din), .sel(sel),
    .en_n(en_n), .clr_n(clr_n), .q(q)
  );

  function automatic logic [7:0] expect_q(logic d, logic [2:0] a, logic e, logic c);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (!e && (a[2]*4 + a[1]*2 + a[0]) == i) r[i] = d;
      else if (!c) r[i] = 1'b0;
      else r[i] = mdl[i];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [7:0] exp_v);
    checks++;
    if (q !== exp_v) begin
      errors++;
      $display("FAIL %s: q=%b expected=%b", tag, q, exp_v);
    end
  endtask

  task automatic step(string tag, logic d, logic [2:0] a, logic e, logic c);
    int idx;
    @(negedge clk);
    din = d; sel = a; en_n = e; clr_n = c;
    #1;
    check(tag, expect_q(d, a, e, c));
    @(posedge clk);
    idx = a[2]*4 + a[1]*2 + a[0];
    if (!c && e) mdl = '0;
    else if (!c && !e) mdl = mdl & (8'd1 << idx);
    else if (e && !m_prev) mdl[idx] = d;
    m_prev = e;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: q=%b expected=completion", q);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1 check("R1 reset", 8'h00);

    // R2 R5: write each address, with a pattern, through an enable pulse
    for (int a = 0; a < 8; a++) begin
      step("R3 open", a[0] ^ a[2], a[2:0], 1'b0, 1'b1);
      step("R5 close", a[0] ^ a[2], a[2:0], 1'b1, 1'b1);
    end
    step("R2 R5 pattern", 1'b0, 3'd0, 1'b1, 1'b1);
    check("R2 pattern 0x5a", 8'h5a);

    // R4: hold mode ignores data and address
    for (int k = 0; k < 16; k++)
      step("R4 hold", k[0], k[3:1], 1'b1, 1'b1);
    check("R4 still 0x5a", 8'h5a);

    // R3: transparent at every address and both data levels
    for (int a = 0; a < 8; a++)
      for (int d = 0; d < 2; d++)
        step("R3 transparent", d[0], a[2:0], 1'b0, 1'b1);
    step("R5 close at 7", 1'b1, 3'd7, 1'b1, 1'b1);
    step("R5 readback", 1'b0, 3'd3, 1'b1, 1'b1);

    // R8: address moves while enable low
    for (int a = 0; a < 8; a++) begin
      step("R5 set", 1'b1, a[2:0], 1'b0, 1'b1);
      step("R5 set", 1'b1, a[2:0], 1'b1, 1'b1);
    end
    step("R8 open at 2", 1'b0, 3'd2, 1'b0, 1'b1);
    step("R8 move to 5", 1'b0, 3'd5, 1'b0, 1'b1);
    step("R8 close at 5", 1'b0, 3'd5, 1'b1, 1'b1);
    step("R8 readback", 1'b1, 3'd1, 1'b1, 1'b1);
    check("R8 bit2 kept, bit5 cleared", 8'hdf);

    // R7: demultiplexer sweep
    for (int a = 0; a < 8; a++)
      for (int d = 0; d < 2; d++)
        step("R7 demux", d[0], a[2:0], 1'b0, 1'b0);
    step("R7 after", 1'b0, 3'd0, 1'b1, 1'b1);

    // R6: clear all, including on a closing edge
    for (int a = 0; a < 8; a++) begin
      step("R5 set", 1'b1, a[2:0], 1'b0, 1'b1);
      step("R5 set", 1'b1, a[2:0], 1'b1, 1'b1);
    end
    step("R6 open", 1'b1, 3'd4, 1'b0, 1'b1);
    step("R6 clear on close", 1'b1, 3'd4, 1'b1, 1'b0);
    step("R6 readback", 1'b1, 3'd4, 1'b1, 1'b1);
    check("R6 bank empty", 8'h00);

    // Full mode sweep
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 8; a++)
        for (int d = 0; d < 2; d++)
          step(m[1] ? (m[0] ? "R4 sweep" : "R3 sweep") : (m[0] ? "R6 sweep" : "R7 sweep"),
               d[0], a[2:0], m[0], m[1]);

    // R1: reset again mid-run
    @(negedge clk); rst = 1'b1; en_n = 1'b1; clr_n = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    mdl = '0; m_prev = 1'b1;
    #1 check("R1 reset again", 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule